// File: doc/BRIEF.md
# Indexed Configuration Space Controller

This block keeps the configuration registers of a multi-function peripheral hub and makes them reachable through a window only two bytes wide. The host first writes a register number into the window's low byte, the pointer. It then reads or writes the high byte, which reaches whatever register that pointer names. A handful of registers are global: a fixed identity byte, a revision byte and a device selector. Everything from pointer 0x30 upward is banked, so the same pointer reaches a different copy of the register for each function number held in the selector.

Each function has an enable flag and a 16-bit window base address, and both are exported to the rest of the chip. The general-purpose pin function, number 7, adds a pin pointer and a per-pin configuration byte. Through these two registers the host sets output enable, drive type and pull-up for any of the pins, one pin at a time. The per-pin settings leave the block as three pin-wide vectors.

Top module: `cfgsp_ctrl`

## Requirements
- R1: A write with `io_addr`=0 loads the pointer with `io_wdata`. A read with `io_addr`=0 returns the current pointer.
- R2: A read with `io_addr`=1 returns the register named by the pointer. `io_rdata` is registered: it takes the new value on the clock edge where `io_rd` is high and holds it while `io_rd` is low.
- R3: Pointer 0x20 reads 0xE9 (parameter `DEV_ID`). Pointer 0x27 reads the revision parameter `REV_ID`, which defaults to 0x03. Writes to either register are ignored.
- R4: Pointer 0x07 is the function selector: 8 bits, read/write. Pointers 0x30 and above act on the function it selects. When the selector is 15 (`NUM_DEV`) or larger, banked reads return 0x00 and banked writes are ignored.
- R5: Pointer 0x30 is the enable register of the selected function. Only bit 0 is stored, and it drives `dev_active[sel]`. Bits 7:1 read back 0.
- R6: Pointers 0x60 and 0x61 hold bits 15:8 and 7:0 of the selected function's base address. The base drives `dev_base[sel*16 +: 16]`.
- R7: When the selector is 7, pointer 0xF0 is an 8-bit pin pointer with the layout (port<<4)|bit. Pointer 0xF1 reaches the configuration of pin port*8+bit. When bit 3 of the pin pointer is set, or the port number is 4 or higher, pointer 0xF1 reads 0x00 and ignores writes.
- R8: In the pin configuration byte, bit 0 is output enable (`pin_oe`), bit 1 selects push-pull when set and open-drain when clear (`pin_pp`), and bit 2 enables the pull-up (`pin_pu`). Bits 7:3 are not stored and read 0.
- R9: When the selector is not 7, pointers 0xF0 and 0xF1 read 0x00 and writes to them are ignored. Every pointer without a register reads 0x00 and ignores writes.
- R10: Synchronous reset clears the pointer, the selector, the pin pointer, every enable, base and pin configuration, and `io_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Write strobe for the window |
| io_rd | input | 1 | Read strobe for the window |
| io_addr | input | 1 | Window offset: 0 = pointer, 1 = data |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| dev_active | output | 15 | Enable flag of each function |
| dev_base | output | 240 | 16-bit base address of each function, function n at bits n*16+15:n*16 |
| pin_oe | output | 32 | Output enable of each pin |
| pin_pp | output | 32 | Push-pull select of each pin |
| pin_pu | output | 32 | Pull-up enable of each pin |

## Verification
The bench drives the selector out of range. A design that kept the banked decode on would let writes land in a nonexistent function, or would wrap them onto function 0. It also uses pin pointers with bit 3 set and with a port of 4. A decoder that ignores those bits would alias such accesses onto real pins and change `pin_oe`. The bench reaches pin registers while a function other than 7 is selected, which catches a decode that forgets the function check. It also writes the identity and revision registers, which shows whether those constants are truly read-only. Random sequences of pointer loads, selector changes and data accesses are checked against a bench model of all storage and the exported vectors. These sequences reveal cross-function corruption and readback through the wrong bank.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    localparam int BASE_W = 16;

    localparam logic [7:0] IDX_LDN  = 8'h07;
    localparam logic [7:0] IDX_ID   = 8'h20;
    localparam logic [7:0] IDX_REV  = 8'h27;
    localparam logic [7:0] IDX_ACT  = 8'h30;
    localparam logic [7:0] IDX_BHI  = 8'h60;
    localparam logic [7:0] IDX_BLO  = 8'h61;
    localparam logic [7:0] IDX_PSEL = 8'hF0;
    localparam logic [7:0] IDX_PCFG = 8'hF1;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_ID,
        RK_REV,
        RK_LDN,
        RK_ACT,
        RK_BHI,
        RK_BLO,
        RK_PSEL,
        RK_PCFG
    } reg_kind_e;

    typedef struct packed {
        logic pu;
        logic pp;
        logic oe;
    } pin_cfg_t;

    function automatic pin_cfg_t byte_to_cfg(input logic [7:0] b);
        pin_cfg_t c;
        c.oe = b[0];
        c.pp = b[1];
        c.pu = b[2];
        return c;
    endfunction

    function automatic logic [7:0] cfg_to_byte(input pin_cfg_t c);
        return {5'b0, c.pu, c.pp, c.oe};
    endfunction

endpackage

// File: rtl/cfgsp_decode.sv
module cfgsp_decode
    import cfgsp_pkg::*;
#(
    parameter int NUM_DEV  = 15,
    parameter int GPIO_LDN = 7
) (
    input  logic [7:0] idx,
    input  logic [7:0] ldn,
    output reg_kind_e  kind
);
    logic dev_ok;
    logic is_gpio;

    assign dev_ok  = (ldn < 8'(NUM_DEV));
    assign is_gpio = (ldn == 8'(GPIO_LDN));

    always_comb begin
        kind = RK_NONE;
        case (idx)
            IDX_ID:   kind = RK_ID;
            IDX_REV:  kind = RK_REV;
            IDX_LDN:  kind = RK_LDN;
            IDX_ACT:  kind = dev_ok ? RK_ACT : RK_NONE;
            IDX_BHI:  kind = dev_ok ? RK_BHI : RK_NONE;
            IDX_BLO:  kind = dev_ok ? RK_BLO : RK_NONE;
            IDX_PSEL: kind = (dev_ok && is_gpio) ? RK_PSEL : RK_NONE;
            IDX_PCFG: kind = (dev_ok && is_gpio) ? RK_PCFG : RK_NONE;
            default:  kind = RK_NONE;
        endcase
    end
endmodule

// File: rtl/cfgsp_dev_bank.sv
module cfgsp_dev_bank
    import cfgsp_pkg::*;
#(
    parameter int NUM_DEV = 15
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_act,
    input  logic                      wr_bhi,
    input  logic                      wr_blo,
    input  logic [7:0]                sel,
    input  logic [7:0]                wdata,
    output logic [NUM_DEV-1:0]        active,
    output logic [NUM_DEV*BASE_W-1:0] base,
    output logic                      rd_act,
    output logic [7:0]                rd_bhi,
    output logic [7:0]                rd_blo
);
    logic [BASE_W-1:0] base_q [NUM_DEV];
    logic              act_q  [NUM_DEV];

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        logic hit;
        assign hit = (sel == 8'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                act_q[g]  <= 1'b0;
                base_q[g] <= '0;
            end else if (hit) begin
                if (wr_act) act_q[g] <= wdata[0];
                if (wr_bhi) base_q[g][15:8] <= wdata;
                if (wr_blo) base_q[g][7:0]  <= wdata;
            end
        end

        assign active[g] = act_q[g];
        assign base[g*BASE_W +: BASE_W] = base_q[g];
    end

    always_comb begin
        rd_act = 1'b0;
        rd_bhi = 8'h00;
        rd_blo = 8'h00;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (sel == 8'(d)) begin
                rd_act = act_q[d];
                rd_bhi = base_q[d][15:8];
                rd_blo = base_q[d][7:0];
            end
        end
    end
endmodule

// File: rtl/cfgsp_pin_bank.sv
module cfgsp_pin_bank
    import cfgsp_pkg::*;
#(
    parameter int NUM_PORTS     = 4,
    parameter int PINS_PER_PORT = 8,
    localparam int NPINS        = NUM_PORTS * PINS_PER_PORT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_psel,
    input  logic             wr_pcfg,
    input  logic [7:0]       wdata,
    output logic [7:0]       psel_q,
    output logic [7:0]       pcfg_rd,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_pp,
    output logic [NPINS-1:0] pin_pu
);
    logic        sel_valid;
    logic [31:0] pin_lin;
    pin_cfg_t    cfg_q [NPINS];

    always_ff @(posedge clk) begin
        if (rst)          psel_q <= 8'h00;
        else if (wr_psel) psel_q <= wdata;
    end

    assign sel_valid = !psel_q[3]
                     && ({4'b0, psel_q[7:4]} < 8'(NUM_PORTS))
                     && ({5'b0, psel_q[2:0]} < 8'(PINS_PER_PORT));
    assign pin_lin = 32'(psel_q[7:4]) * 32'(PINS_PER_PORT) + 32'(psel_q[2:0]);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic hit;
        assign hit = sel_valid && (pin_lin == 32'(p));

        always_ff @(posedge clk) begin
            if (rst)                 cfg_q[p] <= '0;
            else if (wr_pcfg && hit) cfg_q[p] <= byte_to_cfg(wdata);
        end

        assign pin_oe[p] = cfg_q[p].oe;
        assign pin_pp[p] = cfg_q[p].pp;
        assign pin_pu[p] = cfg_q[p].pu;
    end

    always_comb begin
        pcfg_rd = 8'h00;
        for (int p = 0; p < NPINS; p++) begin
            if (sel_valid && pin_lin == 32'(p)) pcfg_rd = cfg_to_byte(cfg_q[p]);
        end
    end
endmodule

// File: rtl/cfgsp_ctrl.sv
module cfgsp_ctrl
    import cfgsp_pkg::*;
#(
    parameter int         NUM_DEV       = 15,
    parameter int         GPIO_LDN      = 7,
    parameter int         NUM_PORTS     = 4,
    parameter int         PINS_PER_PORT = 8,
    parameter logic [7:0] DEV_ID        = 8'hE9,
    parameter logic [7:0] REV_ID        = 8'h03,
    localparam int        NPINS         = NUM_PORTS * PINS_PER_PORT
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      io_wr,
    input  logic                      io_rd,
    input  logic                      io_addr,
    input  logic [7:0]                io_wdata,
    output logic [7:0]                io_rdata,
    output logic [NUM_DEV-1:0]        dev_active,
    output logic [NUM_DEV*BASE_W-1:0] dev_base,
    output logic [NPINS-1:0]          pin_oe,
    output logic [NPINS-1:0]          pin_pp,
    output logic [NPINS-1:0]          pin_pu
);
    logic [7:0] index_q;
    logic [7:0] ldn_q;
    logic [7:0] rdata_q;
    logic [7:0] rd_val;
    reg_kind_e  kind;
    logic       data_wr;
    logic       rd_act;
    logic [7:0] rd_bhi, rd_blo, psel_q, pcfg_rd;

    assign data_wr = io_wr && io_addr;

    cfgsp_decode #(.NUM_DEV(NUM_DEV), .GPIO_LDN(GPIO_LDN)) u_decode (
        .idx  (index_q),
        .ldn  (ldn_q),
        .kind (kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= 8'h00;
            ldn_q   <= 8'h00;
        end else begin
            if (io_wr && !io_addr)            index_q <= io_wdata;
            if (data_wr && kind == RK_LDN)    ldn_q   <= io_wdata;
        end
    end

    cfgsp_dev_bank #(.NUM_DEV(NUM_DEV)) u_dev_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_act (data_wr && kind == RK_ACT),
        .wr_bhi (data_wr && kind == RK_BHI),
        .wr_blo (data_wr && kind == RK_BLO),
        .sel    (ldn_q),
        .wdata  (io_wdata),
        .active (dev_active),
        .base   (dev_base),
        .rd_act (rd_act),
        .rd_bhi (rd_bhi),
        .rd_blo (rd_blo)
    );

    cfgsp_pin_bank #(.NUM_PORTS(NUM_PORTS), .PINS_PER_PORT(PINS_PER_PORT)) u_pin_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_psel (data_wr && kind == RK_PSEL),
        .wr_pcfg (data_wr && kind == RK_PCFG),
        .wdata   (io_wdata),
        .psel_q  (psel_q),
        .pcfg_rd (pcfg_rd),
        .pin_oe  (pin_oe),
        .pin_pp  (pin_pp),
        .pin_pu  (pin_pu)
    );

    always_comb begin
        case (kind)
            RK_ID:   rd_val = DEV_ID;
            RK_REV:  rd_val = REV_ID;
            RK_LDN:  rd_val = ldn_q;
            RK_ACT:  rd_val = {7'b0, rd_act};
            RK_BHI:  rd_val = rd_bhi;
            RK_BLO:  rd_val = rd_blo;
            RK_PSEL: rd_val = psel_q;
            RK_PCFG: rd_val = pcfg_rd;
            default: rd_val = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= 8'h00;
        else if (io_rd) rdata_q <= io_addr ? rd_val : index_q;
    end

    assign io_rdata = rdata_q;
endmodule

// File: rtl/cfgsp_checker.sv
module cfgsp_checker #(
    parameter int         NUM_DEV = 15,
    parameter int         NPINS   = 32,
    parameter logic [7:0] DEV_ID  = 8'hE9
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 io_wr,
    input logic                 io_rd,
    input logic                 io_addr,
    input logic [7:0]           io_wdata,
    input logic [7:0]           io_rdata,
    input logic [7:0]           index_q,
    input logic [NUM_DEV-1:0]   dev_active,
    input logic [NUM_DEV*16-1:0] dev_base,
    input logic [NPINS-1:0]     pin_oe,
    input logic [NPINS-1:0]     pin_pp,
    input logic [NPINS-1:0]     pin_pu
);
    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !io_addr) |=> (index_q == $past(io_wdata))); // R1

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !io_rd |=> $stable(io_rdata)); // R2

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr && index_q == 8'h20) |=> (io_rdata == DEV_ID)); // R3

    AST_ONE_DEV_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $countones(dev_active ^ $past(dev_active)) <= 1); // R5

    AST_BASE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_addr) |=> ($stable(dev_base) && $stable(dev_active))); // R6

    AST_ONE_PIN_CHANGE: assert property (@(posedge clk) disable iff (rst)
        $countones(pin_oe ^ $past(pin_oe)) <= 1); // R7

    AST_PIN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_addr) |=> ($stable(pin_oe) && $stable(pin_pp) && $stable(pin_pu))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (dev_active == '0 && pin_oe == '0 && pin_pu == '0 && io_rdata == 8'h00)); // R10
endmodule

bind cfgsp_ctrl cfgsp_checker #(.NUM_DEV(NUM_DEV), .NPINS(NPINS), .DEV_ID(DEV_ID)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .index_q    (index_q),
    .dev_active (dev_active),
    .dev_base   (dev_base),
    .pin_oe     (pin_oe),
    .pin_pp     (pin_pp),
    .pin_pu     (pin_pu)
);

// File: tb/cfgsp_ctrl_bench.sv
module cfgsp_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NDEV = 15;
    localparam int NPIN = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic io_wr = 1'b0, io_rd = 1'b0, io_addr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic [NDEV-1:0] dev_active;
    logic [NDEV*16-1:0] dev_base;
    logic [NPIN-1:0] pin_oe, pin_pp, pin_pu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m_idx, m_ldn, m_psel;
    logic        m_act  [NDEV];
    logic [15:0] m_base [NDEV];
    logic [2:0]  m_cfg  [NPIN];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgsp_ctrl u_cfgsp_ctrl (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_active(dev_active),
        .dev_base(dev_base), .pin_oe(pin_oe), .pin_pp(pin_pp), .pin_pu(pin_pu)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit psel_ok(input logic [7:0] s);
        return !s[3] && (s[7:4] < 4);
    endfunction

    function automatic int psel_pin(input logic [7:0] s);
        return int'(s[7:4]) * 8 + int'(s[2:0]);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] i);
        case (i)
            8'h20: return 8'hE9;
            8'h27: return 8'h03;
            8'h07: return m_ldn;
            8'h30: return (m_ldn < NDEV) ? {7'b0, m_act[m_ldn]} : 8'h00;
            8'h60: return (m_ldn < NDEV) ? m_base[m_ldn][15:8] : 8'h00;
            8'h61: return (m_ldn < NDEV) ? m_base[m_ldn][7:0] : 8'h00;
            8'hF0: return (m_ldn == 7) ? m_psel : 8'h00;
            8'hF1: return (m_ldn == 7 && psel_ok(m_psel)) ? {5'b0, m_cfg[psel_pin(m_psel)]} : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_write(input logic [7:0] i, input logic [7:0] d);
        case (i)
            8'h07: m_ldn = d;
            8'h30: if (m_ldn < NDEV) m_act[m_ldn] = d[0];
            8'h60: if (m_ldn < NDEV) m_base[m_ldn][15:8] = d;
            8'h61: if (m_ldn < NDEV) m_base[m_ldn][7:0] = d;
            8'hF0: if (m_ldn == 7) m_psel = d;
            8'hF1: if (m_ldn == 7 && psel_ok(m_psel)) m_cfg[psel_pin(m_psel)] = d[2:0];
            default: ;
        endcase
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        if (!a) m_idx = d; else m_write(m_idx, d);
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        @(negedge clk);
        io_rd = 1'b0;
        v = io_rdata;
    endtask

    task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
        bus_wr(1'b0, i);
        bus_wr(1'b1, d);
    endtask

    task automatic reg_chk(input string tag, input logic [7:0] i);
        logic [7:0] v;
        bus_wr(1'b0, i);
        bus_rd(1'b1, v);
        chk(tag, {24'b0, v}, {24'b0, exp_rd(i)});
    endtask

    task automatic outs_chk(input string tag);
        logic [NDEV-1:0] ea;
        logic [NPIN-1:0] eo, ep, eu;
        for (int d = 0; d < NDEV; d++) begin
            ea[d] = m_act[d];
            chk({tag, " R6 base"}, {16'b0, dev_base[d*16 +: 16]}, {16'b0, m_base[d]});
        end
        for (int p = 0; p < NPIN; p++) begin
            eo[p] = m_cfg[p][0]; ep[p] = m_cfg[p][1]; eu[p] = m_cfg[p][2];
        end
        chk({tag, " R5 active"}, {17'b0, dev_active}, {17'b0, ea});
        chk({tag, " R8 oe"}, pin_oe, eo);
        chk({tag, " R8 pp"}, pin_pp, ep);
        chk({tag, " R8 pu"}, pin_pu, eu);
    endtask

    initial begin
        logic [7:0] v;
        m_idx = 0; m_ldn = 0; m_psel = 0;
        for (int d = 0; d < NDEV; d++) begin m_act[d] = 0; m_base[d] = 0; end
        for (int p = 0; p < NPIN; p++) m_cfg[p] = 0;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10 rdata after reset", {24'b0, io_rdata}, 32'h0);
        outs_chk("R10 reset");
        bus_rd(1'b0, v);
        chk("R10 R1 pointer after reset", {24'b0, v}, 32'h0);
        reg_chk("R10 selector after reset", 8'h07);

        bus_wr(1'b0, 8'h5A);
        bus_rd(1'b0, v);
        chk("R1 pointer readback", {24'b0, v}, 32'h5A);
        reg_chk("R9 unimplemented reads zero", 8'h5A);

        reg_chk("R3 id", 8'h20);
        reg_wr(8'h20, 8'h11);
        reg_chk("R3 id after write", 8'h20);
        reg_wr(8'h27, 8'hFF);
        reg_chk("R3 revision", 8'h27);

        reg_wr(8'h07, 8'h04);
        reg_wr(8'h30, 8'hFF);
        reg_chk("R5 enable reads bit0 only", 8'h30);
        reg_wr(8'h60, 8'h12);
        reg_wr(8'h61, 8'h34);
        reg_chk("R6 base hi", 8'h60);
        reg_chk("R6 base lo", 8'h61);
        outs_chk("R5 R6 function 4");

        reg_wr(8'h07, 8'h0F);
        reg_wr(8'h30, 8'h01);
        reg_wr(8'h60, 8'hAB);
        reg_chk("R4 out of range enable", 8'h30);
        reg_chk("R4 out of range base", 8'h60);
        outs_chk("R4 out of range writes ignored");

        reg_wr(8'h07, 8'h03);
        reg_wr(8'hF0, 8'h35);
        reg_wr(8'hF1, 8'h07);
        reg_chk("R9 pin pointer off function 7", 8'hF0);
        outs_chk("R9 pin writes off function 7");

        reg_wr(8'h07, 8'h07);
        reg_wr(8'hF0, 8'h35);
        reg_wr(8'hF1, 8'hFF);
        reg_chk("R7 pin pointer", 8'hF0);
        reg_chk("R8 cfg upper bits zero", 8'hF1);
        chk("R7 pin 29 oe", {31'b0, pin_oe[29]}, 32'h1);
        reg_wr(8'hF0, 8'h3D);
        reg_wr(8'hF1, 8'h05);
        reg_chk("R7 bit3 set reads zero", 8'hF1);
        reg_wr(8'hF0, 8'h42);
        reg_wr(8'hF1, 8'h07);
        reg_chk("R7 port 4 reads zero", 8'hF1);
        outs_chk("R7 invalid pin writes ignored");

        for (int n = 0; n < 300; n++) begin
            logic [31:0] r;
            logic [7:0] i, d;
            r = $urandom();
            case (r[3:0])
                0, 1:    i = 8'h07;
                2:       i = 8'h30;
                3:       i = 8'h60;
                4:       i = 8'h61;
                5, 6:    i = 8'hF0;
                7, 8, 9: i = 8'hF1;
                10:      i = 8'h20;
                11:      i = 8'h27;
                default: i = r[31:24];
            endcase
            d = r[23:16];
            if (i == 8'h07) d = r[8] ? 8'h07 : 8'(r[23:16] % 18);
            if (i == 8'hF0 && r[9]) d = {2'b0, r[21:20], 1'b0, r[18:16]};
            if (r[12]) begin
                reg_wr(i, d);
                if (r[13]) outs_chk("R7 R8 random outputs");
            end else begin
                reg_chk("R2 random read", i);
            end
        end
        outs_chk("R6 R8 final outputs");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule